// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block moves a contiguous run of 32-bit general registers to or from word-addressed memory, one word per memory handshake. A single command chooses one of two range shapes and a direction. The quad shape always moves the four registers r4 to r7, and the command's 4-bit register field names the register that holds the base address. The multiple shape always takes its base address from r0, and the field names the first register of a run that ends at r15. Each of the two shapes can load or store.

The sequencer has one port into the register file. It uses that port to fetch the base address, to read store data and to write load data. On the memory side it drives a word request and waits for a ready response on each word. The base register itself is never written back. The block keeps the address in its own counter, so a run that overwrites its base register still finishes at the addresses taken from the original base value. `busy` is high from the cycle after acceptance until the end of the run. `done` is high for the run's final busy cycle.

Top module: `regblk_xfer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `mem_req` and `rf_wr_en` are low. A reset in the middle of a run abandons the run.
- R2: With `cmd_quad`=1, the block moves exactly registers 4, 5, 6 and 7, in ascending order. The base address is read from the register named by `cmd_reg`.
- R3: With `cmd_quad`=0, the base address is read from register 0. The block moves registers `cmd_reg` through 15 in ascending order, which is 16 minus `cmd_reg` words.
- R4: The first word uses the base address. Each later word uses the previous address plus 4.
- R5: A word stays requested, with its address and register index held, until `mem_ready` is high. Only then does the block move on.
- R6: For a run of N words with W wait cycles per word, `busy` stays high for 2 + N*(W+1) cycles, plus 1 more cycle in quad mode.
- R7: `done` is high for exactly one cycle, the last cycle in which `busy` is high. After that cycle `busy` falls.
- R8: A `cmd_valid` pulse that arrives while `busy` is high is ignored. The current run's data, addresses and length do not change, and no new run starts after it.
- R9: The base address is captured before any transfer. A load that overwrites the base register (register 0 in multiple mode, or a base register inside r4 to r7 in quad mode) still uses consecutive addresses from the captured base.
- R10: `rf_wr_en` is high only on a load word's handshake cycle (`mem_ready` high, `mem_we` low). A store never writes the register file. `mem_we`=1 marks a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_quad | input | 1 | 1 = quad shape (r4..r7), 0 = run up to r15 |
| cmd_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| cmd_reg | input | 4 | Base register (quad) or first register (multiple) |
| rf_idx | output | 4 | Register file index for read and write |
| rf_rd_data | input | 32 | Combinational read data of register `rf_idx` |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_data | output | 32 | Register write data |
| mem_req | output | 1 | Word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Handshake completion for the current word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Final cycle of a run |

## Verification
The bench uses the default parameters: sixteen 32-bit registers, a four-register quad window starting at r4, and 4-byte words. With these values every run length from 1 to 16 words can be reached. So can both ends of the start field (0 and 15), and a base register that sits inside the quad window. The bench's memory model adds 0 to 3 wait cycles per word. This lets the hold-while-waiting rule and the cycle-count formula be checked at several stall depths, together with the quad overhead cycle.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BASE,
        SQ_GAP,
        SQ_MOVE,
        SQ_FIN
    } sq_state_e;

    typedef struct packed {
        logic quad;
        logic load;
    } sq_mode_t;

    function automatic sq_mode_t make_mode(input logic quad, input logic load);
        sq_mode_t m;
        m.quad = quad;
        m.load = load;
        return m;
    endfunction

endpackage

// File: rtl/regblk_plan.sv
module regblk_plan #(
    parameter int NREG       = 16,
    parameter int QUAD_FIRST = 4,
    parameter int QUAD_CNT   = 4,
    localparam int RIDX_W    = $clog2(NREG)
) (
    input  logic              quad,
    input  logic [RIDX_W-1:0] field,
    output logic [RIDX_W-1:0] base_idx,
    output logic [RIDX_W-1:0] first_idx,
    output logic [RIDX_W-1:0] last_idx
);
    localparam logic [RIDX_W-1:0] Q_LO  = RIDX_W'(QUAD_FIRST);
    localparam logic [RIDX_W-1:0] Q_HI  = RIDX_W'(QUAD_FIRST + QUAD_CNT - 1);
    localparam logic [RIDX_W-1:0] TOP_R = RIDX_W'(NREG - 1);

    always_comb begin
        if (quad) begin
            base_idx  = field;
            first_idx = Q_LO;
            last_idx  = Q_HI;
        end else begin
            base_idx  = '0;
            first_idx = field;
            last_idx  = TOP_R;
        end
    end
endmodule

// File: rtl/regblk_agu.sv
module regblk_agu #(
    parameter int ADDR_W     = 32,
    parameter int RIDX_W     = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [RIDX_W-1:0] first_i,
    input  logic [RIDX_W-1:0] last_i,
    input  logic              base_ld,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic [RIDX_W-1:0] idx_o,
    output logic              at_last_o
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    logic [RIDX_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            idx_o  <= '0;
            last_q <= '0;
        end else begin
            if (arm) begin
                idx_o  <= first_i;
                last_q <= last_i;
            end
            if (base_ld) begin
                addr_o <= base_i;
            end
            if (step) begin
                addr_o <= addr_o + STRIDE;
                idx_o  <= idx_o + RIDX_W'(1);
            end
        end
    end

    assign at_last_o = (idx_o == last_q);

    // R4
    addr_stride_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr_o == $past(addr_o) + STRIDE));

    // R2
    idx_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (idx_o == $past(idx_o) + RIDX_W'(1)));
endmodule

// File: rtl/regblk_fsm.sv
module regblk_fsm
    import regblk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  logic      quad_q,
    input  logic      mem_ready,
    input  logic      at_last,
    output sq_state_e state_o,
    output logic      accept,
    output logic      base_ld,
    output logic      step,
    output logic      move,
    output logic      busy,
    output logic      done
);
    sq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: if (cmd_valid) st_d = SQ_BASE;
            SQ_BASE: st_d = quad_q ? SQ_GAP : SQ_MOVE;
            SQ_GAP:  st_d = SQ_MOVE;
            SQ_MOVE: if (mem_ready && at_last) st_d = SQ_FIN;
            SQ_FIN:  st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
    assign accept  = (st_q == SQ_IDLE) && cmd_valid;
    assign base_ld = (st_q == SQ_BASE);
    assign move    = (st_q == SQ_MOVE);
    assign step    = move && mem_ready;
    assign busy    = (st_q != SQ_IDLE);
    assign done    = (st_q == SQ_FIN);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (st_q == SQ_IDLE));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (move && !mem_ready) |=> (st_q == SQ_MOVE));

    // R6
    quad_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (base_ld && quad_q) |=> (st_q == SQ_GAP));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

// File: rtl/regblk_xfer.sv
module regblk_xfer
    import regblk_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int QUAD_FIRST = 4,
    parameter int QUAD_CNT   = 4,
    parameter int WORD_BYTES = 4,
    localparam int RIDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_quad,
    input  logic              cmd_load,
    input  logic [RIDX_W-1:0] cmd_reg,
    output logic [RIDX_W-1:0] rf_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done
);
    sq_mode_t          mode_q;
    logic [RIDX_W-1:0] base_idx_q;
    logic [RIDX_W-1:0] plan_base, plan_first, plan_last;
    logic [RIDX_W-1:0] cur_idx;
    logic              accept, base_ld, step, move, at_last;
    sq_state_e         state;

    regblk_plan #(
        .NREG(NREG), .QUAD_FIRST(QUAD_FIRST), .QUAD_CNT(QUAD_CNT)
    ) u_plan (
        .quad(cmd_quad), .field(cmd_reg),
        .base_idx(plan_base), .first_idx(plan_first), .last_idx(plan_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= make_mode(1'b0, 1'b0);
            base_idx_q <= '0;
        end else if (accept) begin
            mode_q     <= make_mode(cmd_quad, cmd_load);
            base_idx_q <= plan_base;
        end
    end

    regblk_fsm u_fsm (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .quad_q(mode_q.quad),
        .mem_ready(mem_ready), .at_last(at_last), .state_o(state),
        .accept(accept), .base_ld(base_ld), .step(step), .move(move),
        .busy(busy), .done(done)
    );

    regblk_agu #(
        .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .WORD_BYTES(WORD_BYTES)
    ) u_agu (
        .clk(clk), .rst(rst), .arm(accept), .first_i(plan_first),
        .last_i(plan_last), .base_ld(base_ld), .base_i(ADDR_W'(rf_rd_data)),
        .step(step), .addr_o(mem_addr), .idx_o(cur_idx), .at_last_o(at_last)
    );

    assign rf_idx     = (state == SQ_BASE) ? base_idx_q : cur_idx;
    assign mem_req    = move;
    assign mem_we     = move && !mode_q.load;
    assign mem_wdata  = rf_rd_data;
    assign rf_wr_en   = move && mode_q.load && mem_ready;
    assign rf_wr_data = mem_rdata;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req && !rf_wr_en));

    // R2
    quad_base_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_quad) |=> (rf_idx == $past(cmd_reg)));

    // R3
    multi_base_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cmd_quad) |=> (rf_idx == '0));

    // R5
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_idx)));

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_q) && $stable(base_idx_q)));

    // R10
    wr_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (mem_req && mem_ready && !mem_we));
endmodule

// File: tb/tb_regblk_xfer.sv
`timescale 1ns/1ps
module tb_regblk_xfer;
    localparam int NREG = 16;
    localparam int MEMW = 64;

    // fields: [31] quad, [30] load, [27:24] reg, [19:16] wait cycles, [7:0] expected busy cycles
    localparam logic [31:0] VEC [8] = '{
        32'hC200_0007,  // quad load, base in r2
        32'h8901_000B,  // quad store, base in r9, 1 wait
        32'h4C00_0006,  // multiple load from r12
        32'h0302_0029,  // multiple store from r3, 2 waits
        32'h4000_0012,  // multiple load from r0 (overwrites base)
        32'h0F00_0003,  // multiple store of r15 only
        32'hC501_000B,  // quad load, base r5 inside window
        32'h4F03_0006   // multiple load of r15, 3 waits
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_quad = 1'b0, cmd_load = 1'b0;
    logic [3:0]  cmd_reg = '0;
    logic [3:0]  rf_idx;
    logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata;
    logic        rf_wr_en, mem_req, mem_we, mem_ready, busy, done;

    logic [31:0] rf  [NREG];
    logic [31:0] mem [MEMW];
    int stall_n = 0, wait_cnt = 0, hs_cnt = 0;
    logic [31:0] first_addr = '0, last_addr = '0;
    int n_chk = 0, n_bad = 0;

    assign rf_rd_data = rf[rf_idx];
    assign mem_rdata  = mem[mem_addr[7:2]];
    assign mem_ready  = mem_req && (wait_cnt >= stall_n);

    regblk_xfer dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_quad(cmd_quad),
        .cmd_load(cmd_load), .cmd_reg(cmd_reg), .rf_idx(rf_idx),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (rf_wr_en) rf[rf_idx] <= rf_wr_data;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
        else                       wait_cnt <= 0;
        if (mem_req && mem_ready) begin
            if (hs_cnt == 0) first_addr <= mem_addr;
            last_addr <= mem_addr;
            hs_cnt    <= hs_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input bit q, input bit l, input int r, input int s,
                           input int exp_cyc, input int intrude_at, input string dreq);
        logic [31:0] rf_i [NREG];
        logic [31:0] mem_i [MEMW];
        logic [31:0] exp_rf [NREG];
        logic [31:0] exp_mem [MEMW];
        logic [31:0] base;
        int n, first, cyc, dn, last_done, bad_rf, bad_mem;
        base = q ? 32'h10 : 32'h80;
        for (int i = 0; i < NREG; i++) rf_i[i] = 32'hA500_0000 | (i << 8) | i;
        if (q) rf_i[r] = base; else rf_i[0] = base;
        for (int j = 0; j < MEMW; j++) mem_i[j] = 32'h3C00_0000 ^ (j * 32'h0001_0003);
        n     = q ? 4 : 16 - r;
        first = q ? 4 : r;
        exp_rf  = rf_i;
        exp_mem = mem_i;
        for (int k = 0; k < n; k++) begin
            if (l) exp_rf[first + k] = mem_i[(base >> 2) + k];
            else   exp_mem[(base >> 2) + k] = rf_i[first + k];
        end
        @(negedge clk);
        for (int i = 0; i < NREG; i++) rf[i] = rf_i[i];
        for (int j = 0; j < MEMW; j++) mem[j] = mem_i[j];
        stall_n = s;
        hs_cnt  = 0;
        cmd_valid = 1'b1; cmd_quad = q; cmd_load = l; cmd_reg = 4'(r);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0; dn = 0; last_done = -1;
        while (busy && cyc < 1000) begin
            cyc++;
            if (done) begin dn++; last_done = cyc; end
            if (cyc == intrude_at) begin
                cmd_valid = 1'b1; cmd_quad = ~q; cmd_load = ~l; cmd_reg = 4'd1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R6 busy cycles", 32'(cyc), 32'(exp_cyc));
        chk("R7 done count", 32'(dn), 32'd1);
        chk("R7 done on last busy cycle", 32'(last_done), 32'(cyc));
        chk(q ? "R2 word count" : "R3 word count", 32'(hs_cnt), 32'(n));
        chk("R4 first address", first_addr, base);
        chk("R4 last address", last_addr, base + 32'(4 * (n - 1)));
        bad_rf = 0; bad_mem = 0;
        for (int i = 0; i < NREG; i++) if (rf[i] !== exp_rf[i]) bad_rf++;
        for (int j = 0; j < MEMW; j++) if (mem[j] !== exp_mem[j]) bad_mem++;
        chk({dreq, " register contents (R10)"}, 32'(bad_rf), 32'd0);
        chk({dreq, " memory contents"}, 32'(bad_mem), 32'd0);
        @(negedge clk);
        chk("R8 no restart after run", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) rf[i] = '0;
        for (int j = 0; j < MEMW; j++) mem[j] = '0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
        chk("R1 rf_wr_en in reset", 32'(rf_wr_en), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 32'(busy), 32'd0);

        for (int v = 0; v < 8; v++) begin
            logic [31:0] e;
            e = VEC[v];
            run_one(e[31], e[30], int'(e[27:24]), int'(e[19:16]), int'(e[7:0]), -1,
                    (v == 4 || v == 6) ? "R9" : (e[31] ? "R2" : "R3"));
        end

        // R8: a command during a run is ignored
        run_one(1'b0, 1'b0, 3, 2, 41, 3, "R8");
        run_one(1'b1, 1'b1, 7, 0, 7, 2, "R8");

        // R5: long stall keeps the word pending
        run_one(1'b1, 1'b0, 0, 3, 1 + 1 + 16 + 1, -1, "R5");

        // R1: reset in the middle of a run
        @(negedge clk);
        stall_n = 2;
        cmd_valid = 1'b1; cmd_quad = 1'b0; cmd_load = 1'b1; cmd_reg = 4'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 busy after mid-run reset", 32'(busy), 32'd0);
        chk("R1 mem_req after mid-run reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 stays idle", 32'(busy | done), 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule